// File: doc/BRIEF.md
# Chroma 4:4:4 to 4:2:2 Packer

This block takes a stream of 10-bit luma and two chroma samples per pixel and repacks it for a narrower video path. In the reduced format luma keeps its own bus while the two chroma components share a second bus, taking turns from pixel to pixel. The third bus is then idle and held at zero. A full-width mode passes all three components through unchanged, and every mode has the same delay through the block.

The chroma carried on the shared bus is made in one of two ways. It can come from a three-tap low-pass filter with rounding. It can also come from plain subsampling, where every odd pixel's chroma is discarded and the pair reuses the even pixel's sample. A configuration bit chooses which component goes first on each line. The alternation restarts at every line-start strobe. An 8-bit option clears the two lowest bits of every output bus, so that an 8-bit consumer sees no switching on unused lines.

Top module: `chroma_packer`

## Requirements
- R1: With `cfg_fmt422`=0, each valid output pixel carries that input pixel's luma on `bus_a`, its first chroma component (`u_in`) on `bus_b` and its second (`v_in`) on `bus_c`.
- R2: With `cfg_fmt422`=1, `bus_a` still carries luma and `bus_c` is held at zero.
- R3: In 4:2:2, a pixel at even line phase puts `u_in`-derived chroma on `bus_b` when `cfg_order_v`=0 and `v_in`-derived chroma when it is 1; a pixel at odd phase puts the other component.
- R4: The pixel that arrives with `line_start`=1 and `in_valid`=1 has phase 0, and each later valid pixel toggles the phase. A `line_start` pulse while `in_valid`=0 has no effect.
- R5: With `cfg_drop`=0, the chroma on `bus_b` is (left + 2·centre + right + 2) >> 2, taken over that component at the previous, current and next pixels.
- R6: When the previous pixel is missing or the current pixel starts a line, the left tap takes the centre value. When the next pixel is missing or starts a new line, the right tap takes the centre value.
- R7: With `cfg_drop`=1, an even-phase pixel outputs its own selected component unfiltered. An odd-phase pixel outputs its selected component from the previous pixel, with the R6 left-tap substitution.
- R8: With `cfg_8bit`=1, bits [1:0] of `bus_a`, `bus_b` and `bus_c` are zero.
- R9: `out_valid` and `out_sol` follow `in_valid` and `in_valid`&`line_start` exactly three clock edges later, in every mode. Configuration takes effect on the output edge.
- R10: While `out_valid` is 0, all three buses are zero.
- R11: While `rst` is high the outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel qualifier |
| line_start | input | 1 | First pixel of a line (with in_valid) |
| y_in | input | 10 | Luma sample |
| u_in | input | 10 | First chroma component |
| v_in | input | 10 | Second chroma component |
| cfg_fmt422 | input | 1 | 0: three-bus output, 1: two-bus packed output |
| cfg_order_v | input | 1 | 0: line begins with U, 1: line begins with V |
| cfg_drop | input | 1 | 0: filtered chroma, 1: subsampled chroma |
| cfg_8bit | input | 1 | Clear two LSBs on all buses |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Output pixel starts a line |
| bus_a | output | 10 | Luma |
| bus_b | output | 10 | Packed chroma or first chroma component |
| bus_c | output | 10 | Second chroma component or zero |

## Verification
The hardest case to reach is the filter edge, where a line's last pixel is followed directly by the next line's first pixel. There the right tap has to switch to the centre value even though a valid neighbour is present. The stimulus runs lines back to back with zero gap cycles and uses lengths of one, two and odd values. This puts line boundaries at both phases and also gives pixels that are first and last at once. Extreme alternating values and tiny values are used to make the rounding and the tap substitution visible. A configuration switch in the middle of a line checks that the timing of valid and start-of-line does not move.

// File: rtl/chroma_pack_pkg.sv
package chroma_pack_pkg;

    localparam int PIX_W   = 10;
    localparam int N_CHAN  = 3;
    localparam int CH_Y    = 0;
    localparam int CH_U    = 1;
    localparam int CH_V    = 2;
    localparam int N_CHROMA = 2;

    // per-pixel side information travelling with the samples
    typedef struct packed {
        logic valid;
        logic first;
        logic phase;
    } px_tag_t;

    typedef struct packed {
        logic fmt422;
        logic order_v;
        logic drop;
        logic lsb_clr;
    } pk_cfg_t;

    typedef enum logic [1:0] {
        ROUTE_FULL = 2'd0,
        ROUTE_FILT = 2'd1,
        ROUTE_DROP = 2'd2
    } route_e;

    function automatic route_e route_of(input pk_cfg_t c);
        if (!c.fmt422) return ROUTE_FULL;
        return c.drop ? ROUTE_DROP : ROUTE_FILT;
    endfunction

    // which chroma component (0: U, 1: V) a pixel at this phase carries
    function automatic logic comp_index(input logic phase, input logic order_v);
        return phase ^ order_v;
    endfunction

endpackage

// File: rtl/chroma_in_stage.sv
module chroma_in_stage
    import chroma_pack_pkg::*;
#(
    parameter int DW = PIX_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      line_start,
    input  logic [DW-1:0]             y_in,
    input  logic [DW-1:0]             u_in,
    input  logic [DW-1:0]             v_in,
    output px_tag_t                   tag_o,
    output logic [N_CHAN-1:0][DW-1:0] chan_o
);

    logic phase_q;
    logic phase_n;

    always_comb begin
        phase_n = line_start ? 1'b0 : ~phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_o   <= '0;
            phase_q <= 1'b1;
            chan_o  <= '0;
        end else begin
            tag_o.valid <= in_valid;
            tag_o.first <= in_valid & line_start;
            tag_o.phase <= in_valid ? phase_n : 1'b0;
            if (in_valid) begin
                phase_q <= phase_n;
            end
            chan_o[CH_Y] <= y_in;
            chan_o[CH_U] <= u_in;
            chan_o[CH_V] <= v_in;
        end
    end

endmodule

// File: rtl/chroma_window.sv
module chroma_window
    import chroma_pack_pkg::*;
#(
    parameter int DW    = PIX_W,
    parameter int DEPTH = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  px_tag_t                   tag_i,
    input  logic [N_CHAN-1:0][DW-1:0] chan_i,
    output px_tag_t                   tag_c,
    output logic [N_CHAN-1:0][DW-1:0] chan_c,
    output px_tag_t                   tag_l,
    output logic [N_CHAN-1:0][DW-1:0] chan_l
);

    px_tag_t                   tag_q  [DEPTH];
    logic [N_CHAN-1:0][DW-1:0] chan_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tag_q[i]  <= '0;
                chan_q[i] <= '0;
            end
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin
                tag_q[i]  <= tag_q[i-1];
                chan_q[i] <= chan_q[i-1];
            end
            tag_q[0]  <= tag_i;
            chan_q[0] <= chan_i;
        end
    end

    assign tag_c  = tag_q[0];
    assign chan_c = chan_q[0];
    assign tag_l  = tag_q[DEPTH-1];
    assign chan_l = chan_q[DEPTH-1];

endmodule

// File: rtl/chroma_fir_pick.sv
module chroma_fir_pick
    import chroma_pack_pkg::*;
#(
    parameter int DW = PIX_W
) (
    input  px_tag_t                   tag_l,
    input  px_tag_t                   tag_c,
    input  px_tag_t                   tag_r,
    input  logic [N_CHAN-1:0][DW-1:0] chan_l,
    input  logic [N_CHAN-1:0][DW-1:0] chan_c,
    input  logic [N_CHAN-1:0][DW-1:0] chan_r,
    input  pk_cfg_t                   cfg,
    output logic [DW-1:0]             chroma_o
);

    localparam int SW = DW + 2;

    logic left_ok;
    logic right_ok;
    logic [N_CHROMA-1:0][DW-1:0] filt_v;
    logic [N_CHROMA-1:0][DW-1:0] drop_v;

    assign left_ok  = tag_l.valid & ~tag_c.first;
    assign right_ok = tag_r.valid & ~tag_r.first;

    for (genvar gk = 0; gk < N_CHROMA; gk++) begin : g_comp
        logic [DW-1:0] l_tap;
        logic [DW-1:0] c_tap;
        logic [DW-1:0] r_tap;
        logic [SW-1:0] acc;

        assign c_tap = chan_c[CH_U + gk];
        assign l_tap = left_ok  ? chan_l[CH_U + gk] : c_tap;
        assign r_tap = right_ok ? chan_r[CH_U + gk] : c_tap;
        assign acc   = SW'(l_tap) + SW'(r_tap) + {1'b0, c_tap, 1'b0} + SW'(2);

        assign filt_v[gk] = acc[SW-1:2];
        assign drop_v[gk] = tag_c.phase ? l_tap : c_tap;
    end

    logic sel;
    always_comb begin
        sel = comp_index(tag_c.phase, cfg.order_v);
        if (route_of(cfg) == ROUTE_DROP) begin
            chroma_o = drop_v[sel];
        end else begin
            chroma_o = filt_v[sel];
        end
    end

endmodule

// File: rtl/chroma_packer.sv
module chroma_packer
    import chroma_pack_pkg::*;
#(
    parameter int DW       = PIX_W,
    parameter int LSB_ZERO = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          line_start,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] u_in,
    input  logic [DW-1:0] v_in,
    input  logic          cfg_fmt422,
    input  logic          cfg_order_v,
    input  logic          cfg_drop,
    input  logic          cfg_8bit,
    output logic          out_valid,
    output logic          out_sol,
    output logic [DW-1:0] bus_a,
    output logic [DW-1:0] bus_b,
    output logic [DW-1:0] bus_c
);

    localparam logic [DW-1:0] LOW_BITS  = DW'((1 << LSB_ZERO) - 1);
    localparam logic [DW-1:0] KEEP_MASK = ~LOW_BITS;

    pk_cfg_t cfg;
    assign cfg = '{fmt422: cfg_fmt422, order_v: cfg_order_v,
                   drop: cfg_drop, lsb_clr: cfg_8bit};

    px_tag_t                   tag_r, tag_c, tag_l;
    logic [N_CHAN-1:0][DW-1:0] chan_r, chan_c, chan_l;
    logic [DW-1:0]             chroma;

    chroma_in_stage #(.DW(DW)) u_in_stage (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .line_start (line_start),
        .y_in       (y_in),
        .u_in       (u_in),
        .v_in       (v_in),
        .tag_o      (tag_r),
        .chan_o     (chan_r)
    );

    chroma_window #(.DW(DW), .DEPTH(2)) u_window (
        .clk    (clk),
        .rst    (rst),
        .tag_i  (tag_r),
        .chan_i (chan_r),
        .tag_c  (tag_c),
        .chan_c (chan_c),
        .tag_l  (tag_l),
        .chan_l (chan_l)
    );

    chroma_fir_pick #(.DW(DW)) u_pick (
        .tag_l    (tag_l),
        .tag_c    (tag_c),
        .tag_r    (tag_r),
        .chan_l   (chan_l),
        .chan_c   (chan_c),
        .chan_r   (chan_r),
        .cfg      (cfg),
        .chroma_o (chroma)
    );

    logic [DW-1:0] a_n, b_n, c_n;
    logic [DW-1:0] mask;

    always_comb begin
        mask = cfg.lsb_clr ? KEEP_MASK : '1;
        a_n  = '0;
        b_n  = '0;
        c_n  = '0;
        if (tag_c.valid) begin
            a_n = chan_c[CH_Y];
            unique case (route_of(cfg))
                ROUTE_FULL: begin
                    b_n = chan_c[CH_U];
                    c_n = chan_c[CH_V];
                end
                ROUTE_FILT, ROUTE_DROP: begin
                    b_n = chroma;
                end
                default: begin
                    b_n = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_sol   <= 1'b0;
            bus_a     <= '0;
            bus_b     <= '0;
            bus_c     <= '0;
        end else begin
            out_valid <= tag_c.valid;
            out_sol   <= tag_c.valid & tag_c.first;
            bus_a     <= a_n & mask;
            bus_b     <= b_n & mask;
            bus_c     <= c_n & mask;
        end
    end

endmodule

// File: rtl/chroma_packer_chk.sv
module chroma_packer_chk #(
    parameter int DW       = 10,
    parameter int LSB_ZERO = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          line_start,
    input logic          cfg_fmt422,
    input logic          cfg_8bit,
    input logic          out_valid,
    input logic          out_sol,
    input logic [DW-1:0] bus_a,
    input logic [DW-1:0] bus_b,
    input logic [DW-1:0] bus_c
);

    // R9
    lat_valid_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##3 out_valid);

    // R9
    lat_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##3 !out_valid);

    // R4
    sol_align_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && line_start) |-> ##3 out_sol);

    // R4
    sol_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && line_start) |-> ##3 !out_sol);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (bus_a == '0 && bus_b == '0 && bus_c == '0));

    // R2
    third_bus_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_fmt422 |=> (bus_c == '0));

    // R8
    lsb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_8bit |=> (bus_a[LSB_ZERO-1:0] == '0 && bus_b[LSB_ZERO-1:0] == '0
                      && bus_c[LSB_ZERO-1:0] == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_sol && bus_a == '0 && bus_b == '0 && bus_c == '0));

endmodule

bind chroma_packer chroma_packer_chk #(.DW(DW), .LSB_ZERO(LSB_ZERO)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .line_start (line_start),
    .cfg_fmt422 (cfg_fmt422),
    .cfg_8bit   (cfg_8bit),
    .out_valid  (out_valid),
    .out_sol    (out_sol),
    .bus_a      (bus_a),
    .bus_b      (bus_b),
    .bus_c      (bus_c)
);

// File: tb/chroma_packer_tb.sv
module chroma_packer_tb;

    localparam int DW   = 10;
    localparam int HMAX = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic line_start = 1'b0;
    logic [DW-1:0] y_in = '0, u_in = '0, v_in = '0;
    logic cfg_fmt422 = 1'b0, cfg_order_v = 1'b0, cfg_drop = 1'b0, cfg_8bit = 1'b0;
    logic out_valid, out_sol;
    logic [DW-1:0] bus_a, bus_b, bus_c;

    always #10 clk = ~clk;

    chroma_packer #(.DW(DW), .LSB_ZERO(2)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .line_start(line_start),
        .y_in(y_in), .u_in(u_in), .v_in(v_in),
        .cfg_fmt422(cfg_fmt422), .cfg_order_v(cfg_order_v),
        .cfg_drop(cfg_drop), .cfg_8bit(cfg_8bit),
        .out_valid(out_valid), .out_sol(out_sol),
        .bus_a(bus_a), .bus_b(bus_b), .bus_c(bus_c)
    );

    // history of what the design saw at each rising edge
    int h_rst [HMAX];
    int h_val [HMAX];
    int h_fst [HMAX];
    int h_ph  [HMAX];
    int h_y   [HMAX];
    int h_cm  [2][HMAX];
    int h_f422[HMAX];
    int h_ord [HMAX];
    int h_drp [HMAX];
    int h_8b  [HMAX];
    int edge_n = 0;
    int last_ph = 1;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        if (edge_n < HMAX) begin
            int v;
            v = (in_valid && !rst) ? 1 : 0;
            h_rst[edge_n] = rst ? 1 : 0;
            h_val[edge_n] = v;
            h_fst[edge_n] = (v == 1 && line_start) ? 1 : 0;
            if (rst) begin
                last_ph = 1;
                h_ph[edge_n] = 0;
            end else if (v == 1) begin
                h_ph[edge_n] = line_start ? 0 : 1 - last_ph;
                last_ph = h_ph[edge_n];
            end else begin
                h_ph[edge_n] = 0;
            end
            h_y[edge_n]    = int'(y_in);
            h_cm[0][edge_n] = int'(u_in);
            h_cm[1][edge_n] = int'(v_in);
            h_f422[edge_n] = cfg_fmt422 ? 1 : 0;
            h_ord[edge_n]  = cfg_order_v ? 1 : 0;
            h_drp[edge_n]  = cfg_drop ? 1 : 0;
            h_8b[edge_n]   = cfg_8bit ? 1 : 0;
        end
        edge_n = edge_n + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, edge_n - 1, act, exp);
        end
    endtask

    // expected outputs after edge m
    always @(negedge clk) begin
        if (!done && edge_n > 0 && edge_n <= HMAX) begin
            int m, t, ev, es, ea, eb, ec, idx, c, l, r, filt;
            bit lok, rok, edge_case;
            string tb_tag, ta_tag;
            m = edge_n - 1;
            t = m - 2;
            ev = 0; es = 0; ea = 0; eb = 0; ec = 0; edge_case = 1'b0;
            if (h_rst[m] == 1) begin
                chk("R11 valid", int'(out_valid), 0);
                chk("R11 sol", int'(out_sol), 0);
                chk("R11 bus_a", int'(bus_a), 0);
                chk("R11 bus_b", int'(bus_b), 0);
                chk("R11 bus_c", int'(bus_c), 0);
            end else begin
                if (t >= 0 && h_val[t] == 1) begin
                    ev = 1;
                    es = h_fst[t];
                    ea = h_y[t];
                    if (h_f422[m] == 0) begin
                        eb = h_cm[0][t];
                        ec = h_cm[1][t];
                    end else begin
                        idx = h_ph[t] ^ h_ord[m];
                        c = h_cm[idx][t];
                        lok = (t >= 1) && h_val[t-1] == 1 && h_fst[t] == 0;
                        rok = h_val[t+1] == 1 && h_fst[t+1] == 0;
                        edge_case = !lok || !rok;
                        l = lok ? h_cm[idx][t-1] : c;
                        r = rok ? h_cm[idx][t+1] : c;
                        filt = (l + 2 * c + r + 2) / 4;
                        if (h_drp[m] == 1) eb = (h_ph[t] == 1) ? l : c;
                        else eb = filt;
                        ec = 0;
                    end
                    if (h_8b[m] == 1) begin
                        ea = ea & ~3;
                        eb = eb & ~3;
                        ec = ec & ~3;
                    end
                end
                chk("R9 out_valid", int'(out_valid), ev);
                chk("R9 R4 out_sol", int'(out_sol), es);
                if (ev == 0) begin
                    tb_tag = "R10"; ta_tag = "R10";
                end else if (h_f422[m] == 0) begin
                    tb_tag = (h_8b[m] == 1) ? "R1 R8" : "R1";
                    ta_tag = tb_tag;
                end else begin
                    ta_tag = (h_8b[m] == 1) ? "R2 R8" : "R2";
                    if (h_drp[m] == 1) tb_tag = "R7 R3 R4";
                    else if (edge_case) tb_tag = "R6 R3 R4";
                    else tb_tag = "R5 R3 R4";
                end
                chk({ta_tag, " bus_a"}, int'(bus_a), ea);
                chk({tb_tag, " bus_b"}, int'(bus_b), eb);
                chk({ta_tag, " bus_c"}, int'(bus_c), ec);
            end
        end
    end

    task automatic set_cfg(input bit f422, input bit ord, input bit drp, input bit b8);
        cfg_fmt422  = f422;
        cfg_order_v = ord;
        cfg_drop    = drp;
        cfg_8bit    = b8;
    endtask

    // dmode 0: random, 1: alternating extremes, 2: tiny values
    task automatic drive_line(input int len, input int gap, input int dmode);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            in_valid   = 1'b1;
            line_start = (i == 0);
            if (dmode == 1) begin
                y_in = (i % 2) ? 10'h3FF : 10'h000;
                u_in = (i % 2) ? 10'h000 : 10'h3FF;
                v_in = (i % 3 == 0) ? 10'h3FF : 10'h000;
            end else if (dmode == 2) begin
                y_in = DW'($urandom_range(0, 3));
                u_in = DW'($urandom_range(0, 3));
                v_in = DW'($urandom_range(0, 3));
            end else begin
                y_in = DW'($urandom_range(0, 1023));
                u_in = DW'($urandom_range(0, 1023));
                v_in = DW'($urandom_range(0, 1023));
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid   = 1'b0;
            line_start = (g == 0);
            y_in = DW'($urandom_range(0, 1023));
            u_in = DW'($urandom_range(0, 1023));
            v_in = DW'($urandom_range(0, 1023));
        end
    endtask

    task automatic line_set(input int dmode);
        drive_line(8, 0, dmode);
        drive_line(7, 2, dmode);
        drive_line(1, 0, dmode);
        drive_line(2, 0, dmode);
        drive_line(5, 3, dmode);
        drive_line(9, 0, dmode);
        drive_line(3, 4, dmode);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1 full width, then with LSB clearing (R8)
        set_cfg(0, 0, 0, 0); line_set(0);
        set_cfg(0, 0, 0, 1); line_set(0);
        // R5 R6 filtered, both orders, all data styles
        for (int d = 0; d < 3; d++) begin
            set_cfg(1, 0, 0, 0); line_set(d);
            set_cfg(1, 1, 0, 0); line_set(d);
        end
        // R7 subsampled, both orders
        for (int d = 0; d < 3; d++) begin
            set_cfg(1, 0, 1, 0); line_set(d);
            set_cfg(1, 1, 1, 0); line_set(d);
        end
        // R8 with packed output
        set_cfg(1, 0, 0, 1); line_set(0);
        set_cfg(1, 1, 1, 1); line_set(1);

        // R9 configuration switched in the middle of a line
        set_cfg(1, 0, 0, 0);
        fork
            drive_line(12, 3, 0);
            begin
                repeat (5) @(negedge clk);
                set_cfg(0, 0, 0, 0);
                repeat (3) @(negedge clk);
                set_cfg(1, 1, 1, 0);
            end
        join

        // many random short lines, random configuration per line
        for (int k = 0; k < 60; k++) begin
            set_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            drive_line($urandom_range(1, 11), $urandom_range(0, 3), $urandom_range(0, 2));
        end

        @(negedge clk);
        in_valid = 1'b0;
        line_start = 1'b0;
        repeat (6) @(negedge clk);
        finish_run();
    end

endmodule